// File: doc/BRIEF.md
# Ethernet Link Fault Responder

This block sits beside the transmit datapath of an Ethernet port and decides what that path may send while a link fault is present. Each clock carries one received column. The block recognises fault sequence ordered sets in that column stream, turns them into a local-fault or a remote-fault level, and combines that level with a direct local-fault flag from the PCS. It then drives three requests to the transmitter: hold frame data back, replace the current column with idles, or replace it with a Remote Fault ordered set.

A mode input selects how the block responds. In bidirectional mode it follows the usual reconciliation response. A local fault makes the transmitter send only Remote Fault sets. A remote fault makes it send only idles. In unidirectional mode frames keep flowing. Remote Fault sets go out only in columns that the transmitter marks as inter-packet gap, and a received remote fault draws no response. Off mode never touches the transmitter, so older systems keep their behaviour, but the fault levels are still reported.

Top module: `link_fault_responder`

## Requirements
- R1: A received column is a fault sequence set only when the lane-0 control flag is 1, lane 0 holds 0x9C, and the three following bytes (lane 1 in bits 23:16, lane 2 in 15:8, lane 3 in 7:0) read 0x000001 for local fault or 0x000002 for remote fault. Any other code after 0x9C, or 0x9C without the control flag, is not a sequence set.
- R2: A fault of one type is declared when four sets of that type arrive with the fourth no more than 127 columns after the first. The status output rises on the clock edge that samples the fourth set.
- R3: Sets that spread over more than that window do not declare a fault. A set of the other type restarts the count. A set arriving after the window expires starts a new count.
- R4: A declared fault is held until 128 consecutive columns carry no sequence set. The status falls on the edge that samples the 128th such column, and any sequence set restarts that count. A declaration of the other type replaces the current one.
- R5: local_fault is also 1 in any cycle in which pcs_local_fault is 1.
- R6: mode_sel 2'b00 selects bidirectional, 2'b01 unidirectional, 2'b10 off, and 2'b11 acts as bidirectional. The all-zero setting is therefore the default.
- R7: In bidirectional mode with a local fault, tx_insert_rf and tx_hold_frames are 1 and tx_force_idle is 0.
- R8: In bidirectional mode with a remote fault and no local fault, tx_force_idle and tx_hold_frames are 1 and tx_insert_rf is 0.
- R9: In unidirectional mode tx_hold_frames and tx_force_idle stay 0. tx_insert_rf equals local fault AND tx_in_gap, and a remote fault has no effect on the transmit outputs.
- R10: In off mode all three transmit outputs stay 0, while local_fault and remote_fault still report.
- R11: After reset, or with no fault present in any mode, all transmit outputs and both status outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Response mode (00 bidirectional, 01 unidirectional, 10 off, 11 bidirectional) |
| pcs_local_fault | input | 1 | Local fault flag from the PCS |
| rx_lane0_is_ctrl | input | 1 | Lane 0 of the received column is a control character |
| rx_lane0_byte | input | 8 | Lane-0 byte of the received column |
| rx_tail_bytes | input | 24 | Lanes 1..3 of the received column, lane 1 in the top byte |
| tx_in_gap | input | 1 | The transmitter's current column is inter-packet gap |
| tx_hold_frames | output | 1 | Frame data must not be sent |
| tx_force_idle | output | 1 | Replace the transmit column with idles |
| tx_insert_rf | output | 1 | Replace the transmit column with a Remote Fault set |
| local_fault | output | 1 | Local fault level |
| remote_fault | output | 1 | Remote fault level |

## Verification
The checker applies the mode decode on every cycle. Bidirectional responses must hold frames with the right override, unidirectional must never hold frames and may insert only in a gap, and off and fault-free states must leave the transmitter alone. It also checks that the PCS flag always shows as a local fault and that a remote fault rises only after a remote sequence column. The counting behaviour can only be shown by the bench's column scenarios: a fourth set landing exactly on the last window column or one column past it, interleaved types, unknown codes, and a fault clearing on the 128th quiet column but not the 127th.

// File: rtl/link_fault_responder.sv
module link_fault_responder #(
  parameter int SEQ_NEEDED  = 4,
  parameter int WINDOW_COLS = 128,
  parameter int CLEAR_COLS  = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  mode_sel,
  input  logic        pcs_local_fault,
  input  logic        rx_lane0_is_ctrl,
  input  logic [7:0]  rx_lane0_byte,
  input  logic [23:0] rx_tail_bytes,
  input  logic        tx_in_gap,
  output logic        tx_hold_frames,
  output logic        tx_force_idle,
  output logic        tx_insert_rf,
  output logic        local_fault,
  output logic        remote_fault
);
  localparam int CW = $clog2(SEQ_NEEDED + 1);
  localparam int WW = $clog2(WINDOW_COLS + 1);
  localparam int QW = $clog2(CLEAR_COLS + 1);
  localparam logic [CW-1:0] CNT_LAST   = CW'(SEQ_NEEDED - 1);
  localparam logic [WW-1:0] WIN_LIM    = WW'(WINDOW_COLS);
  localparam logic [QW-1:0] QUIET_LAST = QW'(CLEAR_COLS - 1);
  localparam logic [7:0]  SEQ_CTRL = 8'h9C;
  localparam logic [23:0] CODE_LF  = 24'h000001;
  localparam logic [23:0] CODE_RF  = 24'h000002;

  typedef enum logic [1:0] {FLT_NONE, FLT_LOCAL, FLT_REMOTE} fault_e;

  fault_e          grp_kind, flt_q, seq_kind;
  logic [CW-1:0]   grp_cnt;
  logic [WW-1:0]   grp_age, age_next;
  logic [QW-1:0]   quiet_cnt;
  logic            rx_lf, rx_rf, seq_seen, in_window, extend, declare;

  assign rx_lf    = rx_lane0_is_ctrl && rx_lane0_byte == SEQ_CTRL && rx_tail_bytes == CODE_LF;
  assign rx_rf    = rx_lane0_is_ctrl && rx_lane0_byte == SEQ_CTRL && rx_tail_bytes == CODE_RF;
  assign seq_seen = rx_lf || rx_rf;
  assign seq_kind = rx_lf ? FLT_LOCAL : FLT_REMOTE;

  assign age_next  = grp_age + 1'b1;
  assign in_window = (grp_cnt != '0) && (age_next < WIN_LIM);
  assign extend    = seq_seen && in_window && (seq_kind == grp_kind);
  assign declare   = extend && (grp_cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_cnt  <= '0;
      grp_age  <= '0;
      grp_kind <= FLT_NONE;
    end else if (declare) begin
      grp_cnt <= '0;
      grp_age <= '0;
    end else if (extend) begin
      grp_cnt <= grp_cnt + 1'b1;
      grp_age <= age_next;
    end else if (seq_seen) begin
      grp_cnt  <= CW'(1);
      grp_age  <= '0;
      grp_kind <= seq_kind;
    end else if (in_window) begin
      grp_age <= age_next;
    end else begin
      grp_cnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q     <= FLT_NONE;
      quiet_cnt <= '0;
    end else if (declare) begin
      flt_q     <= grp_kind;
      quiet_cnt <= '0;
    end else if (flt_q != FLT_NONE) begin
      if (seq_seen) begin
        quiet_cnt <= '0;
      end else if (quiet_cnt == QUIET_LAST) begin
        flt_q     <= FLT_NONE;
        quiet_cnt <= '0;
      end else begin
        quiet_cnt <= quiet_cnt + 1'b1;
      end
    end
  end

  logic lf_any, rf_any, m_off, m_uni, m_bi;

  assign lf_any = (flt_q == FLT_LOCAL) || pcs_local_fault;
  assign rf_any = (flt_q == FLT_REMOTE);
  assign m_off  = mode_sel == 2'b10;
  assign m_uni  = mode_sel == 2'b01;
  assign m_bi   = !m_off && !m_uni;

  assign tx_insert_rf   = lf_any && (m_bi || (m_uni && tx_in_gap));
  assign tx_force_idle  = m_bi && rf_any && !lf_any;
  assign tx_hold_frames = m_bi && (lf_any || rf_any);
  assign local_fault    = lf_any;
  assign remote_fault   = rf_any;
endmodule

// File: rtl/link_fault_responder_chk.sv
module link_fault_responder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  mode_sel,
  input logic        pcs_local_fault,
  input logic        rx_lane0_is_ctrl,
  input logic [7:0]  rx_lane0_byte,
  input logic [23:0] rx_tail_bytes,
  input logic        tx_in_gap,
  input logic        tx_hold_frames,
  input logic        tx_force_idle,
  input logic        tx_insert_rf,
  input logic        local_fault,
  input logic        remote_fault
);
  logic rf_col, bidir;
  assign rf_col = rx_lane0_is_ctrl && rx_lane0_byte == 8'h9C && rx_tail_bytes == 24'h000002;
  assign bidir  = mode_sel == 2'b00 || mode_sel == 2'b11;

  a_r10_off_leaves_tx: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'b10 |-> !tx_hold_frames && !tx_force_idle && !tx_insert_rf);
  a_r9_uni_never_holds: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'b01 |-> !tx_hold_frames && !tx_force_idle);
  a_r9_uni_gap_only: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01 && tx_insert_rf) |-> tx_in_gap && local_fault);
  a_r7_bidir_local: assert property (@(posedge clk) disable iff (!rst_n)
    (bidir && local_fault) |-> tx_insert_rf && tx_hold_frames && !tx_force_idle);
  a_r8_bidir_remote: assert property (@(posedge clk) disable iff (!rst_n)
    (bidir && remote_fault && !local_fault) |-> tx_force_idle && tx_hold_frames && !tx_insert_rf);
  a_r11_clean_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!local_fault && !remote_fault) |-> !tx_hold_frames && !tx_force_idle && !tx_insert_rf);
  a_r5_pcs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    pcs_local_fault |-> local_fault);
  a_r2_remote_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(remote_fault) |-> $past(rf_col));
  a_r4_remote_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(remote_fault) |-> !$past(rf_col));
endmodule

bind link_fault_responder link_fault_responder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .pcs_local_fault(pcs_local_fault),
  .rx_lane0_is_ctrl(rx_lane0_is_ctrl), .rx_lane0_byte(rx_lane0_byte),
  .rx_tail_bytes(rx_tail_bytes), .tx_in_gap(tx_in_gap), .tx_hold_frames(tx_hold_frames),
  .tx_force_idle(tx_force_idle), .tx_insert_rf(tx_insert_rf),
  .local_fault(local_fault), .remote_fault(remote_fault)
);

// File: tb/link_fault_responder_bench.sv
module link_fault_responder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'b00;
  logic        pcs_local_fault = 1'b0;
  logic        rx_lane0_is_ctrl = 1'b0;
  logic [7:0]  rx_lane0_byte = 8'h07;
  logic [23:0] rx_tail_bytes = 24'h070707;
  logic        tx_in_gap = 1'b0;
  logic        tx_hold_frames, tx_force_idle, tx_insert_rf, local_fault, remote_fault;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  link_fault_responder u_link_fault_responder (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .pcs_local_fault(pcs_local_fault),
    .rx_lane0_is_ctrl(rx_lane0_is_ctrl), .rx_lane0_byte(rx_lane0_byte),
    .rx_tail_bytes(rx_tail_bytes), .tx_in_gap(tx_in_gap), .tx_hold_frames(tx_hold_frames),
    .tx_force_idle(tx_force_idle), .tx_insert_rf(tx_insert_rf),
    .local_fault(local_fault), .remote_fault(remote_fault)
  );

  // {mode, kind(0 none,1 local,2 remote), pcs, gap, hold, idle, insert, lf, rf}
  localparam logic [10:0] TBL [14] = '{
    11'b00_00_0_0_000_00,  // R11 bidir, no fault
    11'b00_01_0_0_101_10,  // R7
    11'b00_10_0_0_110_01,  // R8
    11'b00_10_1_0_101_11,  // R7 local wins over remote
    11'b00_00_1_1_101_10,  // R5 pcs flag alone
    11'b01_01_0_0_000_10,  // R9 outside gap
    11'b01_01_0_1_001_10,  // R9 inside gap
    11'b01_10_0_1_000_01,  // R9 remote ignored
    11'b01_00_1_1_001_10,  // R5 R9
    11'b10_01_0_1_000_10,  // R10
    11'b10_10_0_0_000_01,  // R10
    11'b11_10_0_0_110_01,  // R6 code 11 is bidir
    11'b11_01_0_1_101_10,  // R6
    11'b01_00_0_1_000_00   // R11 uni, no fault
  };

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic col(input logic c, input logic [7:0] b0, input logic [23:0] tail);
    rx_lane0_is_ctrl = c;
    rx_lane0_byte    = b0;
    rx_tail_bytes    = tail;
    @(negedge clk);
  endtask

  task automatic idles(input int n);
    for (int k = 0; k < n; k++) col(1'b1, 8'h07, 24'h070707);
  endtask

  task automatic seqs(input int kind, input int n);
    for (int k = 0; k < n; k++) col(1'b1, 8'h9C, (kind == 1) ? 24'h000001 : 24'h000002);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    pcs_local_fault = 1'b0;
    tx_in_gap = 1'b0;
    mode_sel = 2'b00;
    rx_lane0_is_ctrl = 1'b0;
    rx_lane0_byte = 8'h07;
    rx_tail_bytes = 24'h070707;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    do_reset();
    check("R11", "reset hold", tx_hold_frames, 1'b0);
    check("R11", "reset idle", tx_force_idle, 1'b0);
    check("R11", "reset insert", tx_insert_rf, 1'b0);
    check("R11", "reset lf", local_fault, 1'b0);
    check("R11", "reset rf", remote_fault, 1'b0);

    for (int i = 0; i < 14; i++) begin
      logic [10:0] v;
      v = TBL[i];
      do_reset();
      mode_sel = v[10:9];
      if (v[8:7] != 2'd0) seqs(int'(v[8:7]), 4);
      pcs_local_fault = v[6];
      tx_in_gap = v[5];
      #1;
      check($sformatf("table %0d", i), "hold", tx_hold_frames, v[4]);
      check($sformatf("table %0d", i), "idle", tx_force_idle, v[3]);
      check($sformatf("table %0d", i), "insert", tx_insert_rf, v[2]);
      check($sformatf("table %0d", i), "lf", local_fault, v[1]);
      check($sformatf("table %0d", i), "rf", remote_fault, v[0]);
    end

    // R2: three sets are not enough, the fourth declares
    do_reset();
    seqs(1, 3);
    check("R2", "lf after 3", local_fault, 1'b0);
    seqs(1, 1);
    check("R2", "lf after 4", local_fault, 1'b1);

    // R2: fourth set on column 127 of the window
    do_reset();
    seqs(2, 3); idles(124); seqs(2, 1);
    check("R2", "rf at window edge", remote_fault, 1'b1);

    // R3: fourth set on column 128 starts a new count
    do_reset();
    seqs(2, 3); idles(125); seqs(2, 1);
    check("R3", "rf past window", remote_fault, 1'b0);
    seqs(2, 2);
    check("R3", "rf new group of 3", remote_fault, 1'b0);
    seqs(2, 1);
    check("R3", "rf new group of 4", remote_fault, 1'b1);

    // R3: alternating types never declare
    do_reset();
    for (int k = 0; k < 4; k++) begin seqs(1, 1); seqs(2, 1); end
    check("R3", "interleave lf", local_fault, 1'b0);
    check("R3", "interleave rf", remote_fault, 1'b0);

    // R1: unknown code and missing control flag are not sequence sets
    do_reset();
    for (int k = 0; k < 4; k++) col(1'b1, 8'h9C, 24'h000003);
    check("R1", "unknown code lf", local_fault, 1'b0);
    check("R1", "unknown code rf", remote_fault, 1'b0);
    for (int k = 0; k < 4; k++) col(1'b0, 8'h9C, 24'h000001);
    check("R1", "data 9C", local_fault, 1'b0);
    for (int k = 0; k < 4; k++) col(1'b1, 8'h9C, 24'h010001);
    check("R1", "bad lane1", local_fault, 1'b0);

    // R4: clear after 128 quiet columns, not 127
    do_reset();
    seqs(1, 4); idles(127);
    check("R4", "held at 127", local_fault, 1'b1);
    idles(1);
    check("R4", "cleared at 128", local_fault, 1'b0);

    // R4: a set restarts the quiet count
    do_reset();
    seqs(2, 4); idles(100); seqs(2, 1); idles(127);
    check("R4", "restart held", remote_fault, 1'b1);
    idles(1);
    check("R4", "restart cleared", remote_fault, 1'b0);

    // R4: other type replaces the declared fault
    do_reset();
    seqs(1, 4); seqs(2, 4);
    check("R4", "replace lf", local_fault, 1'b0);
    check("R4", "replace rf", remote_fault, 1'b1);
    check("R8", "replaced idle", tx_force_idle, 1'b1);

    // R5: pcs flag is immediate and leaves no trace
    do_reset();
    pcs_local_fault = 1'b1; #1;
    check("R5", "pcs on", local_fault, 1'b1);
    pcs_local_fault = 1'b0; #1;
    check("R5", "pcs off", local_fault, 1'b0);

    // R9: unidirectional insert follows the gap flag
    do_reset();
    mode_sel = 2'b01; seqs(1, 4);
    tx_in_gap = 1'b1; #1;
    check("R9", "gap insert", tx_insert_rf, 1'b1);
    tx_in_gap = 1'b0; #1;
    check("R9", "frame no insert", tx_insert_rf, 1'b0);
    check("R9", "frame no hold", tx_hold_frames, 1'b0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end
endmodule